// File: doc/BRIEF.md
# LNB Output Fault and Current-Limit Supervisor

This block is the digital supervisor for a regulated output stage made of a step-up converter followed by a linear regulator. It turns two enable bits into separate enables for the converter and the regulator. It watches comparator inputs for regulator overcurrent, die over-temperature, back-bias, low cable current and an out-of-regulation output, and it keeps a registered status flag for each of them. It drives an active-low interrupt pin whenever any flag is set, and it passes a registered two-bit current-limit code to the analog stage.

An overcurrent is handled by one of two policies, chosen by a policy bit. In the retry policy the stage may run at its current limit for an allowance window. If the overload is still present at the end of that window, both power blocks are forced off for a rest window and then re-enabled automatically. This repeats for as long as the overload lasts. In the constant-current policy the stage stays on at its limit and only reports the condition. Both windows are counted in ticks of an external millisecond strobe. The tick counts are parameters and default to 50 and 900.

Top module: `lnb_fault_supervisor`

## Requirements
- R1: With `enBit`=0 both `boostEn` and `ldoEn` are 0. With `enBit`=1 and `dlinBit`=0 only `boostEn` is 1. With both bits at 1, both enables are 1.
- R2: In the retry policy (`dclBit`=1), a regulator overcurrent (`ocDet`=1) sets `olfFlag` one cycle later while both enables stay on. If `ocDet` falls before `ON_TICKS` ticks have been counted, `olfFlag` clears and the stage stays on.
- R3: In the retry policy, an overcurrent that persists for `ON_TICKS` ticks turns both enables off for `OFF_TICKS` ticks. During that time `olfFlag` stays set. The enables then return, and the cycle repeats while the overcurrent lasts.
- R4: In the constant-current policy (`dclBit`=0), the enables never drop because of overcurrent, and `olfFlag` follows `ocDet` with one cycle of delay.
- R5: `limCode` equals `{iselHi, iselLo}` delayed by one cycle. The analog stage reads 2'b11 as 400 mA, 2'b10 as 670 mA, 2'b01 as 790 mA and 2'b00 as 950 mA.
- R6: `otHot`=1 turns both enables off on the next cycle and sets `otfFlag`. The enables return only after `otHot` is released.
- R7: `fltN` is 0 exactly when at least one of `otfFlag`, `cabfFlag`, `ouvfFlag`, `olfFlag` and `bcfFlag` is 1.
- R8: The flags `otfFlag`, `cabfFlag`, `ouvfFlag`, `olfFlag` and `bcfFlag` are registered and stay 0 unless `enBit` and `dlinBit` were both 1 on the previous cycle.
- R9: Clearing `enBit` or `dlinBit` during the forced-off window ends that window. Setting the bits again re-enables the regulator on the next cycle, with no remaining rest time.
- R10: After reset, with all inputs low, both enables are 0, all flags are 0, `fltN` is 1 and `limCode` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| msTick | input | 1 | One-cycle pulse every millisecond |
| ocDet | input | 1 | Linear regulator current-limit comparator |
| otHot | input | 1 | Hysteretic over-temperature comparator |
| bbDet | input | 1 | Back-bias comparator |
| cabDet | input | 1 | Low cable current comparator |
| ouvDet | input | 1 | Output out-of-regulation comparator |
| enBit | input | 1 | Converter enable bit |
| dlinBit | input | 1 | Linear regulator enable bit |
| dclBit | input | 1 | 1 selects the retry policy, 0 the constant-current policy |
| iselHi | input | 1 | Limit select, high bit |
| iselLo | input | 1 | Limit select, low bit |
| boostEn | output | 1 | Converter enable |
| ldoEn | output | 1 | Linear regulator enable |
| olfFlag | output | 1 | Overcurrent flag |
| otfFlag | output | 1 | Over-temperature flag |
| bcfFlag | output | 1 | Back-bias flag |
| cabfFlag | output | 1 | Cable current flag |
| ouvfFlag | output | 1 | Output regulation flag |
| fltN | output | 1 | Active-low interrupt |
| limCode | output | 2 | Current-limit code to the analog stage |

## Verification
The assertions assume that the comparator inputs and register bits change synchronously to `clk`. They also assume `msTick` lasts one cycle and never arrives in two consecutive cycles, so the window counter cannot skip past a limit while the controller is changing state. The bench drives every input on the falling edge. It pulses the tick for one cycle, followed by three idle cycles. In the random phase it keeps `ocDet` and `otHot` low, so that the flag and enable decode can be checked against a closed-form expectation. The timed overcurrent and temperature sequences are exercised by directed runs instead.

// File: rtl/lnbsup_pkg.sv
package lnbsup_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_LIMIT  = 2'd1,
    ST_HICCUP = 2'd2,
    ST_HOT    = 2'd3
  } supState_e;

  typedef struct packed {
    logic clrCnt;   // restart the window counter
    logic cntEn;    // count ms ticks
    logic holdOlf;  // keep overcurrent flag during rest window
    logic ldoOn;    // power blocks currently allowed on
  } supStrobe_t;

endpackage

// File: rtl/lnbsup_ctrl.sv
module lnbsup_ctrl
  import lnbsup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enBit,
  input  logic       dlinBit,
  input  logic       dclBit,
  input  logic       ocDet,
  input  logic       otHot,
  input  logic       onDone,
  input  logic       offDone,
  output supStrobe_t strobe,
  output logic       boostEn,
  output logic       ldoEn
);

  supState_e state, nextState;
  logic ldoReq;
  logic blocksOn;

  assign ldoReq = enBit & dlinBit;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RUN: begin
        if (otHot) nextState = ST_HOT;
        else if (ldoReq && dclBit && ocDet) nextState = ST_LIMIT;
      end
      ST_LIMIT: begin
        if (otHot) nextState = ST_HOT;
        else if (!ldoReq || !dclBit || !ocDet) nextState = ST_RUN;
        else if (onDone) nextState = ST_HICCUP;
      end
      ST_HICCUP: begin
        if (otHot) nextState = ST_HOT;
        else if (!ldoReq || offDone) nextState = ST_RUN;
      end
      ST_HOT: begin
        if (!otHot) nextState = ST_RUN;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  assign blocksOn = (state == ST_RUN) || (state == ST_LIMIT);

  always_comb begin
    strobe.clrCnt  = (nextState != state);
    strobe.cntEn   = (state == ST_LIMIT) || (state == ST_HICCUP);
    strobe.holdOlf = (state == ST_HICCUP);
    strobe.ldoOn   = blocksOn;
  end

  assign boostEn = enBit & blocksOn;
  assign ldoEn   = ldoReq & blocksOn;

  // R1: regulator never runs without the converter
  assert_ldo_needs_boost_R1: assert property (@(posedge clk) disable iff (!rstN)
    ldoEn |-> boostEn);

  // R6: hot die shuts both blocks on the next cycle
  assert_hot_blocks_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    otHot |=> (!boostEn && !ldoEn));

  // R9: dropping an enable bit ends the rest window
  assert_abort_rest_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HICCUP && !ldoReq && !otHot) |=> (state == ST_RUN));

  // R4: constant-current policy never enters the rest window
  assert_static_no_rest_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_HICCUP && !dclBit) |=> (state != ST_HICCUP));

endmodule

// File: rtl/lnbsup_dp.sv
module lnbsup_dp
  import lnbsup_pkg::*;
#(
  parameter int ON_TICKS  = 50,
  parameter int OFF_TICKS = 900
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  supStrobe_t strobe,
  input  logic       enBit,
  input  logic       dlinBit,
  input  logic       ocDet,
  input  logic       otHot,
  input  logic       bbDet,
  input  logic       cabDet,
  input  logic       ouvDet,
  input  logic       iselHi,
  input  logic       iselLo,
  output logic       onDone,
  output logic       offDone,
  output logic       olfFlag,
  output logic       otfFlag,
  output logic       bcfFlag,
  output logic       cabfFlag,
  output logic       ouvfFlag,
  output logic       fltN,
  output logic [1:0] limCode
);

  localparam int MAX_TICKS = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] tickCnt;
  logic ldoReq;

  assign ldoReq = enBit & dlinBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.clrCnt) begin
      tickCnt <= '0;
    end else if (strobe.cntEn && msTick && tickCnt != CNT_W'(MAX_TICKS)) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign onDone  = (tickCnt >= CNT_W'(ON_TICKS));
  assign offDone = (tickCnt >= CNT_W'(OFF_TICKS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      olfFlag  <= 1'b0;
      otfFlag  <= 1'b0;
      bcfFlag  <= 1'b0;
      cabfFlag <= 1'b0;
      ouvfFlag <= 1'b0;
      limCode  <= 2'b00;
    end else begin
      olfFlag  <= ldoReq & (strobe.holdOlf | (ocDet & strobe.ldoOn));
      otfFlag  <= ldoReq & otHot;
      bcfFlag  <= ldoReq & bbDet;
      cabfFlag <= ldoReq & cabDet;
      ouvfFlag <= ldoReq & ouvDet;
      limCode  <= {iselHi, iselLo};
    end
  end

  assign fltN = ~(olfFlag | otfFlag | bcfFlag | cabfFlag | ouvfFlag);

  // R3: window counter stays within its range
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= CNT_W'(MAX_TICKS));

  // R3: overcurrent flag held through the rest window
  assert_olf_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.holdOlf && ldoReq) |=> olfFlag);

  // R8: flags stay clear while the regulator is not requested
  assert_flags_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ldoReq |=> !(olfFlag || otfFlag || bcfFlag || cabfFlag || ouvfFlag));

endmodule

// File: rtl/lnb_fault_supervisor.sv
module lnb_fault_supervisor
  import lnbsup_pkg::*;
#(
  parameter int ON_TICKS  = 50,
  parameter int OFF_TICKS = 900
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       ocDet,
  input  logic       otHot,
  input  logic       bbDet,
  input  logic       cabDet,
  input  logic       ouvDet,
  input  logic       enBit,
  input  logic       dlinBit,
  input  logic       dclBit,
  input  logic       iselHi,
  input  logic       iselLo,
  output logic       boostEn,
  output logic       ldoEn,
  output logic       olfFlag,
  output logic       otfFlag,
  output logic       bcfFlag,
  output logic       cabfFlag,
  output logic       ouvfFlag,
  output logic       fltN,
  output logic [1:0] limCode
);

  supStrobe_t strobe;
  logic onDone, offDone;

  lnbsup_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enBit(enBit), .dlinBit(dlinBit), .dclBit(dclBit),
    .ocDet(ocDet), .otHot(otHot), .onDone(onDone), .offDone(offDone),
    .strobe(strobe), .boostEn(boostEn), .ldoEn(ldoEn)
  );

  lnbsup_dp #(.ON_TICKS(ON_TICKS), .OFF_TICKS(OFF_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .strobe(strobe),
    .enBit(enBit), .dlinBit(dlinBit), .ocDet(ocDet), .otHot(otHot),
    .bbDet(bbDet), .cabDet(cabDet), .ouvDet(ouvDet),
    .iselHi(iselHi), .iselLo(iselLo), .onDone(onDone), .offDone(offDone),
    .olfFlag(olfFlag), .otfFlag(otfFlag), .bcfFlag(bcfFlag),
    .cabfFlag(cabfFlag), .ouvfFlag(ouvfFlag), .fltN(fltN), .limCode(limCode)
  );

endmodule

// File: tb/tb_lnb_fault_supervisor.sv
module tb_lnb_fault_supervisor;

  localparam int ON_T  = 6;
  localparam int OFF_T = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 0, ocDet = 0, otHot = 0, bbDet = 0, cabDet = 0, ouvDet = 0;
  logic enBit = 0, dlinBit = 0, dclBit = 0, iselHi = 0, iselLo = 0;
  logic boostEn, ldoEn, olfFlag, otfFlag, bcfFlag, cabfFlag, ouvfFlag, fltN;
  logic [1:0] limCode;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  lnb_fault_supervisor #(.ON_TICKS(ON_T), .OFF_TICKS(OFF_T)) dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .ocDet(ocDet), .otHot(otHot),
    .bbDet(bbDet), .cabDet(cabDet), .ouvDet(ouvDet), .enBit(enBit),
    .dlinBit(dlinBit), .dclBit(dclBit), .iselHi(iselHi), .iselLo(iselLo),
    .boostEn(boostEn), .ldoEn(ldoEn), .olfFlag(olfFlag), .otfFlag(otfFlag),
    .bcfFlag(bcfFlag), .cabfFlag(cabfFlag), .ouvfFlag(ouvfFlag),
    .fltN(fltN), .limCode(limCode)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expEn(input logic en, input logic dlin);
    return {en, en & dlin};
  endfunction

  function automatic logic [2:0] expFlags(input logic en, input logic dlin,
                                          input logic bb, input logic cab, input logic ouv);
    return (en & dlin) ? {bb, cab, ouv} : 3'b000;
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    msTick = 1'b1;
    step(1);
    msTick = 1'b0;
    step(3);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] ef;
    void'($urandom(32'h1b5e));
    step(3);
    rstN = 1'b1;
    step(2);
    // R10 reset state
    chk({boostEn, ldoEn}, 8'h0, "R10 enables");
    chk({olfFlag, otfFlag, bcfFlag, cabfFlag, ouvfFlag}, 8'h0, "R10 flags");
    chk(fltN, 1, "R10 fltN");
    chk(limCode, 0, "R10 limCode");

    // R1 decode, including en=0 dlin=1
    for (int k = 0; k < 4; k++) begin
      enBit = k[1]; dlinBit = k[0];
      step(1);
      chk({boostEn, ldoEn}, expEn(enBit, dlinBit), "R1 enable decode");
    end

    // R5 directed limit codes
    for (int k = 0; k < 4; k++) begin
      {iselHi, iselLo} = k[1:0];
      step(1);
      chk(limCode, k[1:0], "R5 limit code");
    end

    // random flag/enable/code phase: R1 R5 R7 R8
    for (int k = 0; k < 60; k++) begin
      enBit = 1'($urandom); dlinBit = 1'($urandom); dclBit = 1'($urandom);
      bbDet = 1'($urandom); cabDet = 1'($urandom); ouvDet = 1'($urandom);
      iselHi = 1'($urandom); iselLo = 1'($urandom);
      step(1);
      ef = expFlags(enBit, dlinBit, bbDet, cabDet, ouvDet);
      chk({bcfFlag, cabfFlag, ouvfFlag}, ef, "R8 flag gating");
      chk(fltN, ~|ef, "R7 interrupt");
      chk({boostEn, ldoEn}, expEn(enBit, dlinBit), "R1 random decode");
      chk(limCode, {iselHi, iselLo}, "R5 random code");
    end
    bbDet = 0; cabDet = 0; ouvDet = 0;
    enBit = 1; dlinBit = 1;

    // R2 retry policy, overload clears inside allowance
    dclBit = 1; ocDet = 1;
    step(2);
    chk(olfFlag, 1, "R2 olf set");
    chk(fltN, 0, "R7 olf interrupt");
    chk({boostEn, ldoEn}, 2'b11, "R2 on during allowance");
    ticks(ON_T - 2);
    ocDet = 0;
    step(2);
    chk(olfFlag, 0, "R2 olf clears");
    chk({boostEn, ldoEn}, 2'b11, "R2 still on");
    ticks(ON_T + 2);
    chk({boostEn, ldoEn}, 2'b11, "R2 no late shutdown");

    // R3 persistent overload
    ocDet = 1;
    step(1);
    ticks(ON_T - 1);
    chk({boostEn, ldoEn}, 2'b11, "R3 on before allowance end");
    tick();
    chk({boostEn, ldoEn}, 2'b00, "R3 off after allowance");
    chk(olfFlag, 1, "R3 olf held in rest");
    ticks(OFF_T - 1);
    chk({boostEn, ldoEn}, 2'b00, "R3 off before rest end");
    tick();
    chk({boostEn, ldoEn}, 2'b11, "R3 back on after rest");
    ticks(ON_T);
    chk({boostEn, ldoEn}, 2'b00, "R3 repeat shutdown");

    // R9 abort during rest
    ticks(2);
    dlinBit = 0;
    step(1);
    chk({boostEn, ldoEn}, 2'b10, "R9 abort boost only");
    ocDet = 0;
    step(1);
    chk(olfFlag, 0, "R9 olf clear after abort");
    dlinBit = 1;
    step(1);
    chk({boostEn, ldoEn}, 2'b11, "R9 immediate re-enable");

    // R4 constant-current policy
    dclBit = 0; ocDet = 1;
    step(2);
    chk(olfFlag, 1, "R4 olf follows");
    ticks(ON_T + 3);
    chk({boostEn, ldoEn}, 2'b11, "R4 stays on");
    chk(olfFlag, 1, "R4 olf still set");
    ocDet = 0;
    step(2);
    chk(olfFlag, 0, "R4 olf drops");

    // R6 over-temperature
    otHot = 1;
    step(1);
    chk({boostEn, ldoEn}, 2'b00, "R6 off when hot");
    chk(otfFlag, 1, "R6 otf set");
    chk(fltN, 0, "R7 otf interrupt");
    step(5);
    chk({boostEn, ldoEn}, 2'b00, "R6 stays off while hot");
    otHot = 0;
    step(1);
    chk({boostEn, ldoEn}, 2'b11, "R6 restart on release");
    chk(otfFlag, 0, "R6 otf clear");
    chk(fltN, 1, "R7 no fault");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule